// File: doc/BRIEF.md
# LCD Panel Vertical Timing Generator

This block walks an LCD frame row by row. An upstream horizontal timer gives it a single-cycle line tick at the start of every line period. The block counts those ticks through four phases that repeat in a fixed order: active rows, front porch, vertical sync and back porch. It reports whether the current line carries pixels, which row it is, when a new frame begins, and, for active-matrix (TFT) panels, a frame-sync pulse.

The row count and the sync width are programmed as the value minus one. The two porch lengths are programmed as plain counts, and zero removes that porch. The mode, dual-panel flag and all four length fields are captured once, on the tick that opens a frame, so software can rewrite them at any time without disturbing the frame in progress. On passive (STN) panels, and on any dual-panel setup, the sync interval still uses its line periods but leaves the frame-sync output low. In dual-panel use the row field holds the rows of one half, because both halves are scanned in parallel.

Top module: `lcd_vtiming`

## Requirements
- R1: While reset is asserted, and after reset until the first line tick, frameSync, lineActive, rowIdx and frameStart are all zero. The first line tick after reset opens a frame at row 0.
- R2: Each frame starts with linesCfg+1 active line periods. lineActive is high during them, and rowIdx reads 0 on the first one and rises by one on each later one.
- R3: After the last active row come frontCfg inactive line periods with frameSync low. frontCfg = 0 leads straight into the sync interval.
- R4: When modeTft = 1 and dualPanel = 0, frameSync is high, active high, for exactly syncCfg+1 whole line periods right after the front porch, and never while lineActive is high.
- R5: When modeTft = 0, the sync interval still lasts syncCfg+1 line periods but frameSync stays low, so the frame has frontCfg+syncCfg+1+backCfg inactive line periods.
- R6: After the sync interval come backCfg inactive line periods, then the next frame. backCfg = 0 starts the next frame on the tick that ends the sync interval.
- R7: frameStart is high for exactly one clock, in the clock after the line tick that opens a frame. In that clock lineActive = 1 and rowIdx = 0.
- R8: All configuration inputs are captured on the tick that opens a frame. Changes made during a frame affect only later frames.
- R9: With dualPanel = 1, the active part still lasts linesCfg+1 line periods (one half's rows) and frameSync stays low in either mode.
- R10: The outputs change only in the clock that follows a line tick. In any other clock they hold their value.
- R11: linesCfg = 1023, the largest value, gives 1024 active rows with rowIdx reaching 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineTick | input | 1 | One-clock pulse at the start of each line period |
| modeTft | input | 1 | 1 = active-matrix panel, 0 = passive panel |
| dualPanel | input | 1 | 1 = upper and lower halves scanned together |
| linesCfg | input | LINE_W (10) | Active rows per panel (or per half) minus one |
| frontCfg | input | FP_W (8) | Front porch length in line periods |
| syncCfg | input | SW_W (6) | Sync interval length in line periods minus one |
| backCfg | input | BP_W (8) | Back porch length in line periods |
| frameSync | output | 1 | Frame-sync pulse, active high, TFT single panel only |
| lineActive | output | 1 | Current line period carries pixel rows |
| rowIdx | output | LINE_W (10) | Current row during active lines, zero otherwise |
| frameStart | output | 1 | One-clock strobe as row 0 begins |

## Verification
The hardest case to reach is a configuration change made in the middle of a frame. Alone it changes nothing at the ports, and any mistake only shows up one whole frame later. The stimulus therefore loads the next table entry right after each frame-start strobe. It then measures the running frame's active, porch and sync lengths against the entry that was captured earlier. The same walk covers the degenerate frames (one row, no porches, one sync line) and the 1024-row maximum, where a counter wrap or a skipped zero-length phase would shift every later boundary.

// File: rtl/lcd_vtiming_pkg.sv
`timescale 1ns/1ps
package lcd_vtiming_pkg;

  typedef enum logic [2:0] {
    PH_WAIT   = 3'd0,
    PH_ACTIVE = 3'd1,
    PH_FRONT  = 3'd2,
    PH_SYNC   = 3'd3,
    PH_BACK   = 3'd4
  } vtPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic clrCnt;
    logic incCnt;
  } vtCtrl_t;

  // compare results from datapath to control
  typedef struct packed {
    logic atLastRow;
    logic atFrontEnd;
    logic atSyncEnd;
    logic atBackEnd;
    logic frontNone;
    logic backNone;
    logic syncShown;
  } vtStat_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lcd_vtiming_dp.sv
`timescale 1ns/1ps
module lcd_vtiming_dp
  import lcd_vtiming_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int FP_W   = 8,
  parameter int SW_W   = 6,
  parameter int BP_W   = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  vtCtrl_t           ctrl,
  input  logic              modeTft,
  input  logic              dualPanel,
  input  logic [LINE_W-1:0] linesCfg,
  input  logic [FP_W-1:0]   frontCfg,
  input  logic [SW_W-1:0]   syncCfg,
  input  logic [BP_W-1:0]   backCfg,
  output vtStat_t           stat,
  output logic [CNT_W-1:0]  cnt
);

  logic [LINE_W-1:0] linesQ;
  logic [FP_W-1:0]   frontQ;
  logic [SW_W-1:0]   syncQ;
  logic [BP_W-1:0]   backQ;
  logic              showSyncQ;
  logic [CNT_W:0]    cntPlus;

  // frame-level configuration snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linesQ    <= '0;
      frontQ    <= '0;
      syncQ     <= '0;
      backQ     <= '0;
      showSyncQ <= 1'b0;
    end else if (ctrl.loadCfg) begin
      linesQ    <= linesCfg;
      frontQ    <= frontCfg;
      syncQ     <= syncCfg;
      backQ     <= backCfg;
      showSyncQ <= modeTft & ~dualPanel;
    end
  end

  // shared line counter for every phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.clrCnt) begin
      cnt <= '0;
    end else if (ctrl.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntPlus = {1'b0, cnt} + 1'b1;

  always_comb begin
    stat.atLastRow  = (cnt == CNT_W'(linesQ));
    stat.atSyncEnd  = (cnt == CNT_W'(syncQ));
    stat.atFrontEnd = (cntPlus == (CNT_W+1)'(frontQ));
    stat.atBackEnd  = (cntPlus == (CNT_W+1)'(backQ));
    stat.frontNone  = (frontQ == '0);
    stat.backNone   = (backQ == '0);
    stat.syncShown  = showSyncQ;
  end

endmodule

// File: rtl/lcd_vtiming_ctrl.sv
`timescale 1ns/1ps
module lcd_vtiming_ctrl
  import lcd_vtiming_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineTick,
  input  vtStat_t  stat,
  output vtCtrl_t  ctrl,
  output vtPhase_t phase,
  output logic     frameStart
);

  vtPhase_t phaseNext;
  logic     startNow;

  always_comb begin
    phaseNext = phase;
    ctrl      = '0;
    startNow  = 1'b0;
    if (lineTick) begin
      ctrl.incCnt = 1'b1;
      unique case (phase)
        PH_WAIT: begin
          startNow = 1'b1;
        end
        PH_ACTIVE: begin
          if (stat.atLastRow) begin
            ctrl.clrCnt = 1'b1;
            phaseNext   = stat.frontNone ? PH_SYNC : PH_FRONT;
          end
        end
        PH_FRONT: begin
          if (stat.atFrontEnd) begin
            ctrl.clrCnt = 1'b1;
            phaseNext   = PH_SYNC;
          end
        end
        PH_SYNC: begin
          if (stat.atSyncEnd) begin
            if (stat.backNone) begin
              startNow = 1'b1;
            end else begin
              ctrl.clrCnt = 1'b1;
              phaseNext   = PH_BACK;
            end
          end
        end
        PH_BACK: begin
          if (stat.atBackEnd) startNow = 1'b1;
        end
        default: startNow = 1'b1;
      endcase
      if (startNow) begin
        ctrl.clrCnt  = 1'b1;
        ctrl.loadCfg = 1'b1;
        phaseNext    = PH_ACTIVE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_WAIT;
      frameStart <= 1'b0;
    end else begin
      phase      <= phaseNext;
      frameStart <= startNow;
    end
  end

endmodule

// File: rtl/lcd_vtiming.sv
`timescale 1ns/1ps
module lcd_vtiming
  import lcd_vtiming_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int FP_W   = 8,
  parameter int SW_W   = 6,
  parameter int BP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineTick,
  input  logic              modeTft,
  input  logic              dualPanel,
  input  logic [LINE_W-1:0] linesCfg,
  input  logic [FP_W-1:0]   frontCfg,
  input  logic [SW_W-1:0]   syncCfg,
  input  logic [BP_W-1:0]   backCfg,
  output logic              frameSync,
  output logic              lineActive,
  output logic [LINE_W-1:0] rowIdx,
  output logic              frameStart
);

  localparam int CNT_W = maxOf4(LINE_W, FP_W, SW_W, BP_W);

  vtCtrl_t          ctrl;
  vtStat_t          stat;
  vtPhase_t         phase;
  logic [CNT_W-1:0] cnt;

  lcd_vtiming_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .lineTick   (lineTick),
    .stat       (stat),
    .ctrl       (ctrl),
    .phase      (phase),
    .frameStart (frameStart)
  );

  lcd_vtiming_dp #(
    .LINE_W (LINE_W),
    .FP_W   (FP_W),
    .SW_W   (SW_W),
    .BP_W   (BP_W),
    .CNT_W  (CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .modeTft   (modeTft),
    .dualPanel (dualPanel),
    .linesCfg  (linesCfg),
    .frontCfg  (frontCfg),
    .syncCfg   (syncCfg),
    .backCfg   (backCfg),
    .stat      (stat),
    .cnt       (cnt)
  );

  assign lineActive = (phase == PH_ACTIVE);
  assign rowIdx     = lineActive ? cnt[LINE_W-1:0] : '0;
  assign frameSync  = (phase == PH_SYNC) && stat.syncShown;

endmodule

// File: rtl/lcd_vtiming_checker.sv
`timescale 1ns/1ps
module lcd_vtiming_checker #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineTick,
  input logic              frameSync,
  input logic              lineActive,
  input logic [LINE_W-1:0] rowIdx,
  input logic              frameStart
);

  assert_sync_not_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> !lineActive);

  assert_start_row0_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (lineActive && rowIdx == '0));

  assert_start_after_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(lineTick));

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lineTick) |-> ($stable(rowIdx) && $stable(lineActive) && $stable(frameSync)));

  assert_row_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lineActive && $past(lineActive) && $past(lineTick))
      |-> (rowIdx == LINE_W'($past(rowIdx) + 1'b1)));

endmodule

bind lcd_vtiming lcd_vtiming_checker #(.LINE_W(LINE_W)) checker_i (
  .clk        (clk),
  .rstN       (rstN),
  .lineTick   (lineTick),
  .frameSync  (frameSync),
  .lineActive (lineActive),
  .rowIdx     (rowIdx),
  .frameStart (frameStart)
);

// File: tb/lcd_vtiming_tb_top.sv
`timescale 1ns/1ps
module lcd_vtiming_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineTick = 1'b0;
  logic       modeTft = 1'b0;
  logic       dualPanel = 1'b0;
  logic [9:0] linesCfg = '0;
  logic [7:0] frontCfg = '0;
  logic [5:0] syncCfg = '0;
  logic [7:0] backCfg = '0;
  logic       frameSync, lineActive, frameStart;
  logic [9:0] rowIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       sSync, sActive, sStart;
  logic [9:0] sRow;

  always #2.5 clk = ~clk;

  lcd_vtiming dut_i (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .modeTft(modeTft),
    .dualPanel(dualPanel), .linesCfg(linesCfg), .frontCfg(frontCfg),
    .syncCfg(syncCfg), .backCfg(backCfg), .frameSync(frameSync),
    .lineActive(lineActive), .rowIdx(rowIdx), .frameStart(frameStart)
  );

  // fields: tft[33] dual[32] lines[31:22] front[21:14] sync[13:8] back[7:0]
  localparam int NVEC = 7;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 10'd4,    8'd2,   6'd1,  8'd3},
    {1'b1, 1'b0, 10'd0,    8'd0,   6'd0,  8'd0},
    {1'b0, 1'b0, 10'd3,    8'd2,   6'd2,  8'd1},
    {1'b1, 1'b1, 10'd5,    8'd1,   6'd0,  8'd2},
    {1'b1, 1'b0, 10'd2,    8'd255, 6'd63, 8'd255},
    {1'b1, 1'b0, 10'd1023, 8'd0,   6'd0,  8'd0},
    {1'b0, 1'b0, 10'd0,    8'd0,   6'd0,  8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyCfg(input logic [33:0] v);
    modeTft   = v[33];
    dualPanel = v[32];
    linesCfg  = v[31:22];
    frontCfg  = v[21:14];
    syncCfg   = v[13:8];
    backCfg   = v[7:0];
  endtask

  task automatic sampleOut();
    sSync = frameSync; sActive = lineActive; sStart = frameStart; sRow = rowIdx;
  endtask

  // tick, sample the clock after, then confirm hold and strobe width
  task automatic doTick();
    @(negedge clk) lineTick = 1'b1;
    @(negedge clk) lineTick = 1'b0;
    sampleOut();
    @(negedge clk);
    chk(frameStart == 1'b0, "R7 strobe width", frameStart, 0);
    chk({frameSync, lineActive, rowIdx} == {sSync, sActive, sRow}, "R10 hold",
        {frameSync, lineActive, rowIdx}, {sSync, sActive, sRow});
  endtask

  task automatic measureFrame(input logic [33:0] v, input logic [33:0] nextV);
    int activeN, preN, syncN, postN;
    bit ended, showSync;
    string tagA;
    activeN = 1; preN = 0; syncN = 0; postN = 0; ended = 0;
    chk(sActive && sRow == 0, "R7 row0 at start", sRow, 0);
    applyCfg(nextV); // mid-frame change, must not affect this frame (R8)
    for (int n = 0; n < 4000; n++) begin
      doTick();
      if (sStart) begin ended = 1; break; end
      if (sActive) begin
        chk(sRow == 10'(activeN), "R2 row index", sRow, activeN);
        activeN++;
      end else if (sSync) syncN++;
      else if (syncN == 0) preN++;
      else postN++;
    end
    chk(ended, "R8 frame end seen", ended, 1);
    showSync = v[33] && !v[32];
    tagA = v[32] ? "R9 active rows" : (v[31:22] == 10'd1023 ? "R11 active rows" : "R2 active rows");
    chk(activeN == int'(v[31:22]) + 1, tagA, activeN, int'(v[31:22]) + 1);
    if (showSync) begin
      chk(preN == int'(v[21:14]), "R3 front porch", preN, int'(v[21:14]));
      chk(syncN == int'(v[13:8]) + 1, "R4 sync lines", syncN, int'(v[13:8]) + 1);
      chk(postN == int'(v[7:0]), "R6 back porch", postN, int'(v[7:0]));
    end else begin
      chk(syncN == 0, v[32] ? "R9 sync suppressed" : "R5 sync suppressed", syncN, 0);
      chk(preN == int'(v[21:14]) + int'(v[13:8]) + 1 + int'(v[7:0]), "R5 inactive lines",
          preN, int'(v[21:14]) + int'(v[13:8]) + 1 + int'(v[7:0]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({frameSync, lineActive, rowIdx, frameStart} == '0, "R1 in reset",
        {frameSync, lineActive, rowIdx, frameStart}, 0);
    rstN = 1'b1;
    applyCfg(VEC[0]);
    repeat (4) @(negedge clk);
    chk({frameSync, lineActive, rowIdx, frameStart} == '0, "R1 idle before tick",
        {frameSync, lineActive, rowIdx, frameStart}, 0);
    doTick();
    chk(sStart == 1'b1, "R1 first tick opens frame", sStart, 1);
    chk(sActive == 1'b1, "R7 active on start", sActive, 1);

    for (int i = 0; i < NVEC; i++) begin
      measureFrame(VEC[i], VEC[(i + 1) % NVEC]);
    end

    // reset in the middle of a frame clears every output
    doTick();
    doTick();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    chk({frameSync, lineActive, rowIdx, frameStart} == '0, "R1 reset mid-frame",
        {frameSync, lineActive, rowIdx, frameStart}, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({frameSync, lineActive, rowIdx, frameStart} == '0, "R1 idle after reset",
        {frameSync, lineActive, rowIdx, frameStart}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule